// File: doc/BRIEF.md
# DDR Controller Register Shell

This block gives boot firmware the register behaviour it expects while bringing up DRAM, and it drives no real memory. It presents three banks of 32-bit registers on one simple read/write bus. The window select picks the bank. The three banks are a common bank, a controller bank and a PHY bank, and each spans 4 KiB of byte offsets. The number of registers in each bank is a parameter. Every register is plain storage except where one of the rules below applies.

Several status flags come from side effects rather than from real training:

- A write to the controller's PHY-start register sets the init-done and active flags.
- A read strobe into the empty second-rank region can set a read-timeout flag, but only when timeouts are enabled in the PHY configuration register.
- A write to the common control register with single-rank mode decodes the row, bank and column address widths. These widths go to a registered geometry output with a one-cycle update pulse.

Top module: `dram_reg_shell`

## Requirements
- R1: Reset (synchronous, active high) clears every register in all three banks to zero, clears the geometry outputs and clears the read data.
- R2: Only word-aligned accesses (byte offset bits [1:0] equal 0) take effect. A misaligned write is dropped, and a misaligned read returns zero.
- R3: A register index (offset bits [11:2]) at or above the bank's register count reads as zero, and a write to it changes no register.
- R4: An in-range aligned write stores the whole 32-bit word. Read data is registered and appears the cycle after the read strobe. On a cycle after no read strobe it is zero. A read and a write in the same cycle return the value held before the write.
- R5: Window select 0 is the common bank, 1 the controller bank and 2 the PHY bank. Select 3 reaches no register: it reads zero and drops writes. The three banks hold separate values at the same offset.
- R6: A write to the common control register (offset 0x000) with bit 0 clear drives the geometry outputs in the following cycle. The row width becomes bits[7:4]+1, the bank width becomes bit[2]+2 and the column width becomes bits[11:8]+3. The update pulse is high for exactly that one cycle.
- R7: A control write with bit 0 set (dual rank) stores the value but leaves the geometry outputs unchanged and gives no update pulse.
- R8: Any write to controller offset 0x000 stores its value and also sets bit 0 of controller offset 0x010 (PHY status, init done) and bit 0 of controller offset 0x018 (status, active).
- R9: A probe read strobe while bit 25 of controller offset 0x100 is set sets bit 13 (read timeout) of controller offset 0x010. With bit 25 clear, the probe has no effect.
- R10: When a bus write to the PHY status register and a flag-setting event fall in the same cycle, the register takes the written value with the flag bits ORed in.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 2 | Window select: 0 common, 1 controller, 2 PHY, 3 none |
| bus_addr | input | 12 | Byte offset within the window |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data, valid the cycle after bus_rd |
| probe_rd | input | 1 | Read strobe from the second-rank probe region |
| geo_row | output | 5 | Decoded row address width |
| geo_bank | output | 2 | Decoded bank address width |
| geo_col | output | 5 | Decoded column address width |
| geo_upd | output | 1 | One-cycle pulse when the geometry outputs change |

## Verification
The bench builds the block with 4 common, 68 controller and 8 PHY registers. The controller bank must stay above index 64 so that the configuration register at 0x100 exists. The small common and PHY counts put out-of-range indices just above the last real register, so the boundary between storage and the zero-reading hole is exercised at both ends of that bank. These counts also keep a full read sweep of every bank short, so reset clearing can be checked on every implemented word after a run has dirtied them.

// File: rtl/dram_shell_pkg.sv
package dram_shell_pkg;
  typedef enum logic [1:0] {
    WIN_COM  = 2'd0,
    WIN_CTL  = 2'd1,
    WIN_PHY  = 2'd2,
    WIN_NONE = 2'd3
  } win_e;

  // controller-bank word indices whose behaviour is special
  localparam int unsigned PSTART_IDX = 0;   // byte 0x000
  localparam int unsigned PSTAT_IDX  = 4;   // byte 0x010
  localparam int unsigned STAT_IDX   = 6;   // byte 0x018
  localparam int unsigned PCFG_IDX   = 64;  // byte 0x100

  localparam int unsigned DONE_BIT   = 0;
  localparam int unsigned ACT_BIT    = 0;
  localparam int unsigned TMO_BIT    = 13;
  localparam int unsigned TMO_EN_BIT = 25;
  localparam int unsigned DUAL_BIT   = 0;

  typedef struct packed {
    logic [4:0] row;
    logic [1:0] bank;
    logic [4:0] col;
  } geom_t;
endpackage

// File: rtl/dram_reg_bank.sv
module dram_reg_bank #(
  parameter int unsigned NREGS = 8,
  parameter int unsigned IW    = 10
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   wr_en,
  input  logic [IW-1:0]          wr_idx,
  input  logic [31:0]            wr_data,
  input  logic [NREGS-1:0][31:0] set_bits,
  output logic [NREGS-1:0][31:0] regs_q
);
  for (genvar g = 0; g < NREGS; g++) begin : g_word
    always_ff @(posedge clk) begin
      if (rst)
        regs_q[g] <= '0;
      else if (wr_en && wr_idx == IW'(g))
        regs_q[g] <= wr_data | set_bits[g];
      else
        regs_q[g] <= regs_q[g] | set_bits[g];
    end
  end
endmodule

// File: rtl/dram_geom_decode.sv
module dram_geom_decode
  import dram_shell_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       load,
  input  logic [3:0] row_f,
  input  logic       bank_f,
  input  logic [3:0] col_f,
  output geom_t      geom,
  output logic       upd
);
  always_ff @(posedge clk) begin
    if (rst) begin
      geom <= '0;
      upd  <= 1'b0;
    end else begin
      upd <= load;
      if (load) begin
        geom.row  <= 5'(row_f) + 5'd1;
        geom.bank <= {1'b1, bank_f};
        geom.col  <= 5'(col_f) + 5'd3;
      end
    end
  end
endmodule

// File: rtl/dram_reg_shell.sv
module dram_reg_shell
  import dram_shell_pkg::*;
#(
  parameter int unsigned WIN_BYTES = 4096,
  parameter int unsigned COM_REGS  = 8,
  parameter int unsigned CTL_REGS  = 72,
  parameter int unsigned PHY_REGS  = 16
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic [1:0]                   bus_sel,
  input  logic [$clog2(WIN_BYTES)-1:0] bus_addr,
  input  logic                         bus_wr,
  input  logic                         bus_rd,
  input  logic [31:0]                  bus_wdata,
  output logic [31:0]                  bus_rdata,
  input  logic                         probe_rd,
  output logic [4:0]                   geo_row,
  output logic [1:0]                   geo_bank,
  output logic [4:0]                   geo_col,
  output logic                         geo_upd
);
  localparam int unsigned AW = $clog2(WIN_BYTES);
  localparam int unsigned IW = AW - 2;

  logic [IW-1:0] idx;
  logic          aligned, wr_ok;
  logic          com_wr, ctl_wr, phy_wr;
  logic          start_wr, tmo_set, geom_load;

  logic [COM_REGS-1:0][31:0] com_q;
  logic [CTL_REGS-1:0][31:0] ctl_q, ctl_set;
  logic [PHY_REGS-1:0][31:0] phy_q;
  logic [31:0] pstat_q, stat_q, pcfg_q, rd_word;
  geom_t geom;

  assign idx     = bus_addr[AW-1:2];
  assign aligned = (bus_addr[1:0] == 2'b00);
  assign wr_ok   = bus_wr && aligned;

  assign com_wr = wr_ok && bus_sel == WIN_COM && idx < IW'(COM_REGS);
  assign ctl_wr = wr_ok && bus_sel == WIN_CTL && idx < IW'(CTL_REGS);
  assign phy_wr = wr_ok && bus_sel == WIN_PHY && idx < IW'(PHY_REGS);

  assign pstat_q = ctl_q[PSTAT_IDX];
  assign stat_q  = ctl_q[STAT_IDX];
  assign pcfg_q  = ctl_q[PCFG_IDX];

  assign start_wr  = ctl_wr && idx == IW'(PSTART_IDX);
  assign tmo_set   = probe_rd && pcfg_q[TMO_EN_BIT];
  assign geom_load = com_wr && idx == '0 && !bus_wdata[DUAL_BIT];

  always_comb begin
    ctl_set = '0;
    if (start_wr) begin
      ctl_set[PSTAT_IDX][DONE_BIT] = 1'b1;
      ctl_set[STAT_IDX][ACT_BIT]   = 1'b1;
    end
    if (tmo_set)
      ctl_set[PSTAT_IDX][TMO_BIT] = 1'b1;
  end

  dram_reg_bank #(.NREGS(COM_REGS), .IW(IW)) u_com (
    .clk(clk), .rst(rst), .wr_en(com_wr), .wr_idx(idx), .wr_data(bus_wdata),
    .set_bits('0), .regs_q(com_q));

  dram_reg_bank #(.NREGS(CTL_REGS), .IW(IW)) u_ctl (
    .clk(clk), .rst(rst), .wr_en(ctl_wr), .wr_idx(idx), .wr_data(bus_wdata),
    .set_bits(ctl_set), .regs_q(ctl_q));

  dram_reg_bank #(.NREGS(PHY_REGS), .IW(IW)) u_phy (
    .clk(clk), .rst(rst), .wr_en(phy_wr), .wr_idx(idx), .wr_data(bus_wdata),
    .set_bits('0), .regs_q(phy_q));

  dram_geom_decode u_geom (
    .clk(clk), .rst(rst), .load(geom_load),
    .row_f(bus_wdata[7:4]), .bank_f(bus_wdata[2]), .col_f(bus_wdata[11:8]),
    .geom(geom), .upd(geo_upd));

  always_comb begin
    rd_word = '0;
    case (bus_sel)
      WIN_COM: for (int i = 0; i < COM_REGS; i++) if (idx == IW'(i)) rd_word = com_q[i];
      WIN_CTL: for (int i = 0; i < CTL_REGS; i++) if (idx == IW'(i)) rd_word = ctl_q[i];
      WIN_PHY: for (int i = 0; i < PHY_REGS; i++) if (idx == IW'(i)) rd_word = phy_q[i];
      default: rd_word = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)
      bus_rdata <= '0;
    else
      bus_rdata <= (bus_rd && aligned) ? rd_word : '0;
  end

  assign geo_row  = geom.row;
  assign geo_bank = geom.bank;
  assign geo_col  = geom.col;
endmodule

// File: rtl/dram_reg_shell_chk.sv
module dram_reg_shell_chk (
  input logic        clk,
  input logic        rst,
  input logic [1:0]  bus_sel,
  input logic [11:0] bus_addr,
  input logic        bus_wr,
  input logic        bus_rd,
  input logic [31:0] bus_wdata,
  input logic [31:0] bus_rdata,
  input logic        probe_rd,
  input logic [4:0]  geo_row,
  input logic [1:0]  geo_bank,
  input logic [4:0]  geo_col,
  input logic        geo_upd,
  input logic [31:0] pstat_q,
  input logic [31:0] stat_q,
  input logic [31:0] pcfg_q
);
  // R8
  start_sets_flags_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && bus_sel == 2'd1 && bus_addr == 12'h000) |=> (pstat_q[0] && stat_q[0]));

  // R9
  probe_sets_timeout_chk: assert property (@(posedge clk) disable iff (rst)
    (probe_rd && pcfg_q[25]) |=> pstat_q[13]);

  // R6
  geom_update_source_chk: assert property (@(posedge clk) disable iff (rst)
    geo_upd |-> $past(bus_wr && bus_sel == 2'd0 && bus_addr == 12'h000 && !bus_wdata[0]));

  // R6
  geom_bank_range_chk: assert property (@(posedge clk) disable iff (rst)
    geo_upd |-> geo_bank[1]);

  // R7
  geom_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !geo_upd |-> $stable({geo_row, geo_bank, geo_col}));

  // R4
  idle_rdata_zero_chk: assert property (@(posedge clk) disable iff (rst)
    !$past(bus_rd) |-> bus_rdata == 32'h0);

  // R2
  misaligned_read_zero_chk: assert property (@(posedge clk) disable iff (rst)
    $past(bus_rd && bus_addr[1:0] != 2'b00) |-> bus_rdata == 32'h0);

  // R5
  no_window_read_zero_chk: assert property (@(posedge clk) disable iff (rst)
    $past(bus_rd && bus_sel == 2'd3) |-> bus_rdata == 32'h0);
endmodule

bind dram_reg_shell dram_reg_shell_chk u_chk (
  .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_addr(bus_addr),
  .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
  .probe_rd(probe_rd), .geo_row(geo_row), .geo_bank(geo_bank), .geo_col(geo_col),
  .geo_upd(geo_upd), .pstat_q(pstat_q), .stat_q(stat_q), .pcfg_q(pcfg_q));

// File: tb/sim_dram_reg_shell.sv
`timescale 1ns/1ps
module sim_dram_reg_shell;
  localparam int COM_N = 4;
  localparam int CTL_N = 68;
  localparam int PHY_N = 8;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [1:0]  bus_sel = '0;
  logic [11:0] bus_addr = '0;
  logic        bus_wr = 1'b0, bus_rd = 1'b0, probe_rd = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [4:0]  geo_row, geo_col;
  logic [1:0]  geo_bank;
  logic        geo_upd;

  always #4 clk = ~clk;

  dram_reg_shell #(.WIN_BYTES(4096), .COM_REGS(COM_N), .CTL_REGS(CTL_N), .PHY_REGS(PHY_N)) u0 (
    .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .probe_rd(probe_rd),
    .geo_row(geo_row), .geo_bank(geo_bank), .geo_col(geo_col), .geo_upd(geo_upd));

  // behavioural reference state
  logic [31:0] m_com [COM_N];
  logic [31:0] m_ctl [CTL_N];
  logic [31:0] m_phy [PHY_N];
  int m_row, m_bank, m_col;
  int n_cmp = 0, n_bad = 0;
  bit done = 0;

  task automatic chk(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  function automatic logic [31:0] mread(input logic [1:0] s, input int i);
    case (s)
      2'd0: return (i < COM_N) ? m_com[i] : 32'h0;
      2'd1: return (i < CTL_N) ? m_ctl[i] : 32'h0;
      2'd2: return (i < PHY_N) ? m_phy[i] : 32'h0;
      default: return 32'h0;
    endcase
  endfunction

  task automatic mclear();
    for (int i = 0; i < COM_N; i++) m_com[i] = 0;
    for (int i = 0; i < CTL_N; i++) m_ctl[i] = 0;
    for (int i = 0; i < PHY_N; i++) m_phy[i] = 0;
    m_row = 0; m_bank = 0; m_col = 0;
  endtask

  // one bus cycle; the model advances alongside and outputs are compared after the edge
  task automatic cyc(input logic [1:0] s, input logic [11:0] a, input logic w, input logic r,
                     input logic [31:0] d, input logic p, input string tag);
    logic [31:0] exp_rd;
    int i;
    logic ok, start, tmo, exp_upd;
    bus_sel = s; bus_addr = a; bus_wr = w; bus_rd = r; bus_wdata = d; probe_rd = p;
    i = int'(a[11:2]);
    ok = (a[1:0] == 2'b00);
    exp_rd = (r && ok) ? mread(s, i) : 32'h0;
    start = w && ok && s == 2'd1 && i == 0;
    tmo = p && m_ctl[64][25];
    exp_upd = 1'b0;
    if (w && ok) begin
      if (s == 2'd0 && i < COM_N) begin
        m_com[i] = d;
        if (i == 0 && !d[0]) begin
          m_row = int'(d[7:4]) + 1; m_bank = int'(d[2]) + 2; m_col = int'(d[11:8]) + 3;
          exp_upd = 1'b1;
        end
      end
      if (s == 2'd1 && i < CTL_N) m_ctl[i] = d;
      if (s == 2'd2 && i < PHY_N) m_phy[i] = d;
    end
    if (start) begin m_ctl[4][0] = 1'b1; m_ctl[6][0] = 1'b1; end
    if (tmo) m_ctl[4][13] = 1'b1;
    @(posedge clk); #2;
    chk(tag, "rdata", bus_rdata, exp_rd);
    chk(tag, "row", 32'(geo_row), 32'(m_row));
    chk(tag, "bank", 32'(geo_bank), 32'(m_bank));
    chk(tag, "col", 32'(geo_col), 32'(m_col));
    chk(tag, "upd", 32'(geo_upd), 32'(exp_upd));
    @(negedge clk);
  endtask

  task automatic wr(input logic [1:0] s, input logic [11:0] a, input logic [31:0] d, input string tag);
    cyc(s, a, 1'b1, 1'b0, d, 1'b0, tag);
  endtask
  task automatic rd(input logic [1:0] s, input logic [11:0] a, input string tag);
    cyc(s, a, 1'b0, 1'b1, 32'h0, 1'b0, tag);
    cyc(s, a, 1'b0, 1'b0, 32'h0, 1'b0, tag);
  endtask

  task automatic do_reset();
    rst = 1'b1; bus_wr = 0; bus_rd = 0; probe_rd = 0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    mclear();
  endtask

  task automatic sweep(input string tag);
    for (int i = 0; i < COM_N; i++) rd(2'd0, 12'(i * 4), tag);
    for (int i = 0; i < CTL_N; i++) rd(2'd1, 12'(i * 4), tag);
    for (int i = 0; i < PHY_N; i++) rd(2'd2, 12'(i * 4), tag);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    mclear();
    @(negedge clk);
    do_reset();
    // R1: everything reads zero after reset
    sweep("R1");
    // R4: storage with distinct patterns, idle cycles read zero
    for (int i = 0; i < PHY_N; i++) wr(2'd2, 12'(i * 4), 32'hA5A5_0000 ^ (32'h1111_1111 * i), "R4");
    for (int i = 0; i < PHY_N; i++) rd(2'd2, 12'(i * 4), "R4");
    wr(2'd2, 12'h004, 32'hFFFF_FFFF, "R4");
    rd(2'd2, 12'h004, "R4");
    // R4: read and write in the same cycle return the old value
    cyc(2'd2, 12'h008, 1'b1, 1'b1, 32'h0BAD_F00D, 1'b0, "R4");
    rd(2'd2, 12'h008, "R4");
    // R5: window select separation and the empty select
    wr(2'd0, 12'h004, 32'h1111_0001, "R5");
    wr(2'd1, 12'h004, 32'h2222_0002, "R5");
    wr(2'd2, 12'h004, 32'h3333_0003, "R5");
    wr(2'd3, 12'h004, 32'h4444_0004, "R5");
    rd(2'd0, 12'h004, "R5"); rd(2'd1, 12'h004, "R5");
    rd(2'd2, 12'h004, "R5"); rd(2'd3, 12'h004, "R5");
    // R3: out-of-range indices
    wr(2'd2, 12'h020, 32'hDEAD_BEEF, "R3");
    rd(2'd2, 12'h020, "R3"); rd(2'd2, 12'h01C, "R3"); rd(2'd2, 12'h000, "R3");
    wr(2'd0, 12'h010, 32'hCAFE_0000, "R3");
    rd(2'd0, 12'h010, "R3"); rd(2'd0, 12'h00C, "R3");
    wr(2'd1, 12'hFFC, 32'h1234_5678, "R3");
    rd(2'd1, 12'hFFC, "R3");
    // R2: misaligned accesses
    wr(2'd2, 12'h00D, 32'h5555_5555, "R2");
    rd(2'd2, 12'h00C, "R2"); rd(2'd2, 12'h00D, "R2"); rd(2'd2, 12'h00E, "R2");
    wr(2'd1, 12'h002, 32'h0, "R2");
    rd(2'd1, 12'h010, "R2");
    // R6: geometry decode, several patterns
    wr(2'd0, 12'h000, 32'h0000_0A58, "R6");
    cyc(2'd0, 12'h000, 1'b0, 1'b0, 32'h0, 1'b0, "R6");
    wr(2'd0, 12'h000, 32'h0000_0FF4, "R6");
    wr(2'd0, 12'h000, 32'h0000_0000, "R6");
    rd(2'd0, 12'h000, "R6");
    // R7: dual rank keeps geometry, value still stored
    wr(2'd0, 12'h000, 32'h0000_0A58, "R7");
    wr(2'd0, 12'h000, 32'h0000_0331, "R7");
    rd(2'd0, 12'h000, "R7");
    // R8: PHY start side effects
    rd(2'd1, 12'h010, "R8"); rd(2'd1, 12'h018, "R8");
    wr(2'd1, 12'h000, 32'h1234_0000, "R8");
    rd(2'd1, 12'h000, "R8"); rd(2'd1, 12'h010, "R8"); rd(2'd1, 12'h018, "R8");
    // R9: probe without and with timeout enable
    cyc(2'd3, 12'h000, 1'b0, 1'b0, 32'h0, 1'b1, "R9");
    rd(2'd1, 12'h010, "R9");
    wr(2'd1, 12'h100, 32'h0200_0000, "R9");
    cyc(2'd3, 12'h000, 1'b0, 1'b0, 32'h0, 1'b1, "R9");
    rd(2'd1, 12'h010, "R9");
    // R10: write to PHY status coinciding with probe and with start
    wr(2'd1, 12'h010, 32'h0, "R10");
    rd(2'd1, 12'h010, "R10");
    cyc(2'd1, 12'h010, 1'b1, 1'b0, 32'h0000_0100, 1'b1, "R10");
    rd(2'd1, 12'h010, "R10");
    // R1: reset after a dirty run clears everything again
    do_reset();
    cyc(2'd3, 12'h000, 1'b0, 1'b0, 32'h0, 1'b0, "R1");
    sweep("R1");
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule